// File: doc/BRIEF.md
# Range-Matching Translation Buffer with Pinned Slots

This block is a small, fully associative address translation buffer. Every entry covers a virtual range, held as an inclusive start and last address. An entry also holds a physical page base and a 30-bit attribute word. A lookup returns whether some valid entry covers the presented address. On a hit it also returns the translated physical address and that entry's attributes, one clock later. When several entries cover the address, the entry with the lowest index is used.

The entries are split into two groups. Slots 0 to 3 are pinned block slots. They are written only by their own insert and purge commands, and they can cover many pages. Slots 4 to 15 are ordinary single-page entries. An ordinary entry is filled in two steps: an insert-address command reserves a slot and records the page, then an insert-protection command supplies the attributes and makes the entry valid. Purge-by-address and purge-all remove ordinary entries only.

Commands arrive one per cycle on `cmd_valid`/`cmd_op`, with operands on the remaining command inputs. A misordered protection command raises `err_seq` for one cycle. A pinned-slot command with a slot number that does not exist raises `err_arg` for one cycle. Permission checking is left to the consumer of `lk_attr`.

Top module: `range_tlb`

## Requirements
- R1: An entry matches when it is valid and start ≤ `lk_addr` ≤ last. If the lowest-index matching entry exists, the next cycle shows `lk_hit`=1, `lk_pa` = its physical base + (`lk_addr` − start) and `lk_attr` = its attributes. If no entry matches, `lk_hit`, `lk_pa` and `lk_attr` are all 0.
- R2: Insert-address (`cmd_op`=1) does the following:
  - It first invalidates every ordinary entry that overlaps the 4 KiB page holding `cmd_addr`.
  - It then reserves a pending entry with start = `cmd_addr` rounded down to 4 KiB, last = start + 4095 and physical page number = `cmd_data[24:5]` (base = that number × 4096).
  - The pending entry does not hit until it is completed.
- R3: Insert-protection (`cmd_op`=2) completes the pending entry only if an entry is pending and `cmd_addr` lies inside its range. Otherwise nothing becomes valid and `err_seq` is 1 in the next cycle only. The pending state is cleared in both cases.
- R4: Completing an entry stores `cmd_data[29:1]` at the same positions of `lk_attr`: access id [18:1], U [19], PL2 [21:20], PL1 [23:22], type [26:24], B [27], D [28], T [29]. `lk_attr[0]` is always 0.
- R5: Insert-address allocates a slot as follows:
  - It takes the lowest-index free ordinary slot. Slots freed by its own purge step count as free.
  - When no ordinary slot is free, it takes a round-robin slot and evicts that slot's entry. The round-robin pointer starts at slot 4, advances by one per use and wraps from 15 back to 4.
- R6: Purge-by-address (`cmd_op`=3) invalidates every ordinary entry whose range contains `cmd_addr` and frees its slot. Pinned entries stay valid.
- R7: Purge-all (`cmd_op`=4) does the following; pinned entries are unaffected:
  - It invalidates and frees all ordinary slots.
  - It resets the round-robin pointer to slot 4.
  - It cancels any pending insert.
- R8: Pinned insert (`cmd_op`=5) with `pin_slot` < 4 replaces that slot with:
  - start = `pin_vpn`×4096, last = start + `pin_len`×4096 − 1 and physical base `pin_ppn`×4096;
  - attributes from `cmd_data` as in R4, with T forced to 0 and D forced to 1.
- R9: Pinned insert or pinned purge with `pin_slot` ≥ 4 changes nothing and sets `err_arg` to 1 in the next cycle only.
- R10: Pinned purge (`cmd_op`=6) invalidates slot `pin_slot`. Purge-all-pinned (`cmd_op`=7) invalidates all four pinned slots.
- R11: After reset, no entry is valid, no insert is pending, and `lk_hit`, `err_seq` and `err_arg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 32 | Lookup virtual address |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (1..7, see requirements) |
| cmd_addr | input | 32 | Address operand of ordinary commands |
| cmd_data | input | 32 | Physical page or protection operand |
| pin_slot | input | 4 | Pinned slot number |
| pin_vpn | input | 20 | Pinned insert virtual page number |
| pin_ppn | input | 20 | Pinned insert physical page number |
| pin_len | input | 20 | Pinned insert length in pages |
| lk_hit | output | 1 | Registered lookup hit |
| lk_pa | output | 32 | Registered physical address (0 on miss) |
| lk_attr | output | 30 | Registered attributes of the matched entry (0 on miss) |
| err_seq | output | 1 | One-cycle pulse: protection command dropped |
| err_arg | output | 1 | One-cycle pulse: pinned slot number out of range |

## Verification
The bench fills all twelve ordinary slots and sweeps every page at its first, middle and last byte. It then forces evictions, and a wrong round-robin start or a pointer that is not reset by purge-all would make the wrong page disappear. Overlapping pinned ranges and an ordinary page placed under a pinned range expose a priority encoder that picks the highest index, as well as purges that wrongly remove pinned entries. Protection commands are sent with nothing pending, with an address outside the pending page and after a purge-all. Pinned commands are sent with slot numbers just past and far past the pinned group. A design that forgets to clear the pending state, or that accepts a bad slot, produces a hit where a miss is expected.

// File: rtl/range_tlb_pkg.sv
`timescale 1ns/1ps
package range_tlb_pkg;
    parameter int TLB_AW     = 32;   // virtual address width
    parameter int TLB_PGB    = 12;   // page offset width
    parameter int TLB_PPN_W  = 20;   // physical page number width
    parameter int TLB_ATTR_W = 30;   // attribute word width
    parameter int TLB_DW     = 32;   // command data width

    typedef enum logic [2:0] {
        OP_NOP          = 3'd0,
        OP_INS_ADDR     = 3'd1,
        OP_INS_PROT     = 3'd2,
        OP_PURGE_ADDR   = 3'd3,
        OP_PURGE_ALL    = 3'd4,
        OP_PIN_INS      = 3'd5,
        OP_PIN_PURGE    = 3'd6,
        OP_PIN_PURGE_AL = 3'd7
    } tlb_op_e;

    typedef struct packed {
        logic                  vld;
        logic [TLB_AW-1:0]     lo;
        logic [TLB_AW-1:0]     hi;
        logic [TLB_PPN_W-1:0]  ppn;
        logic [TLB_ATTR_W-1:0] attr;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_lowest.sv
`timescale 1ns/1ps
module tlb_lowest #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_range_match.sv
`timescale 1ns/1ps
module tlb_range_match
    import range_tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_entry_t [N-1:0] ent,
    input  logic [TLB_AW-1:0]  q_lo,
    input  logic [TLB_AW-1:0]  q_hi,
    output logic [N-1:0]       ov
);
    // An entry overlaps the query [q_lo, q_hi] when both ranges intersect.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign ov[g] = ent[g].vld && (ent[g].lo <= q_hi) && (ent[g].hi >= q_lo);
    end
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
    parameter int NPIN = 4,
    parameter int NORD = 12,
    localparam int NENT = NPIN + NORD,
    localparam int IW   = $clog2(NENT),
    localparam int OW   = (NORD > 1) ? $clog2(NORD) : 1
) (
    input  logic [NORD-1:0] free_in,
    input  logic [IW-1:0]   rr,
    output logic [IW-1:0]   slot,
    output logic            use_rr,
    output logic [IW-1:0]   rr_next
);
    logic          f_any;
    logic [OW-1:0] f_idx;

    tlb_lowest #(.N(NORD), .IW(OW)) u_free_pick (
        .req (free_in),
        .any (f_any),
        .idx (f_idx)
    );

    assign use_rr  = !f_any;
    assign slot    = f_any ? (IW'(NPIN) + IW'(f_idx)) : rr;
    assign rr_next = (rr == IW'(NENT - 1)) ? IW'(NPIN) : (rr + 1'b1);
endmodule

// File: rtl/range_tlb.sv
`timescale 1ns/1ps
module range_tlb
    import range_tlb_pkg::*;
#(
    parameter int NPIN   = 4,
    parameter int NORD   = 12,
    parameter int SLOT_W = 4,
    localparam int NENT  = NPIN + NORD,
    localparam int IW    = $clog2(NENT),
    localparam int VPN_W = TLB_AW - TLB_PGB,
    localparam int PA_W  = TLB_PPN_W + TLB_PGB
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TLB_AW-1:0]     lk_addr,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [TLB_AW-1:0]     cmd_addr,
    input  logic [TLB_DW-1:0]     cmd_data,
    input  logic [SLOT_W-1:0]     pin_slot,
    input  logic [VPN_W-1:0]      pin_vpn,
    input  logic [TLB_PPN_W-1:0]  pin_ppn,
    input  logic [VPN_W-1:0]      pin_len,
    output logic                  lk_hit,
    output logic [PA_W-1:0]       lk_pa,
    output logic [TLB_ATTR_W-1:0] lk_attr,
    output logic                  err_seq,
    output logic                  err_arg
);
    typedef struct packed {
        tlb_entry_t [NENT-1:0]  ent;
        logic [NORD-1:0]        free;
        logic [IW-1:0]          rr;
        logic                   pend;
        logic [IW-1:0]          pend_slot;
        logic                   hit;
        logic [PA_W-1:0]        pa;
        logic [TLB_ATTR_W-1:0]  attr;
        logic                   err_seq;
        logic                   err_arg;
    } state_t;

    state_t q, d;

    tlb_op_e op;
    assign op = cmd_valid ? tlb_op_e'(cmd_op) : OP_NOP;

    // Page window of the command address.
    logic [TLB_AW-1:0] page_lo, page_hi;
    assign page_lo = {cmd_addr[TLB_AW-1:TLB_PGB], {TLB_PGB{1'b0}}};
    assign page_hi = {cmd_addr[TLB_AW-1:TLB_PGB], {TLB_PGB{1'b1}}};

    // Command-side overlap: whole page for insert-address, one byte otherwise.
    logic [TLB_AW-1:0] cq_lo, cq_hi;
    assign cq_lo = (op == OP_INS_ADDR) ? page_lo : cmd_addr;
    assign cq_hi = (op == OP_INS_ADDR) ? page_hi : cmd_addr;

    logic [NENT-1:0] cmd_ov;
    tlb_range_match #(.N(NENT)) u_cmd_match (
        .ent  (q.ent),
        .q_lo (cq_lo),
        .q_hi (cq_hi),
        .ov   (cmd_ov)
    );

    // Lookup side.
    logic [NENT-1:0] lk_vec;
    logic            lk_any;
    logic [IW-1:0]   lk_idx;
    logic [PA_W-1:0] lk_pa_c;

    tlb_range_match #(.N(NENT)) u_lk_match (
        .ent  (q.ent),
        .q_lo (lk_addr),
        .q_hi (lk_addr),
        .ov   (lk_vec)
    );

    tlb_lowest #(.N(NENT), .IW(IW)) u_lk_pick (
        .req (lk_vec),
        .any (lk_any),
        .idx (lk_idx)
    );

    assign lk_pa_c = {q.ent[lk_idx].ppn, {TLB_PGB{1'b0}}}
                   + PA_W'(lk_addr - q.ent[lk_idx].lo);

    // Slot choice for insert-address; freed-by-this-purge slots count as free.
    logic [NORD-1:0] vic_free;
    logic [IW-1:0]   vic_slot, vic_rr_next, ins_slot;
    logic            vic_rr;

    assign vic_free = q.free | cmd_ov[NENT-1:NPIN];

    tlb_victim #(.NPIN(NPIN), .NORD(NORD)) u_victim (
        .free_in (vic_free),
        .rr      (q.rr),
        .slot    (vic_slot),
        .use_rr  (vic_rr),
        .rr_next (vic_rr_next)
    );

    logic slot_ok;
    assign slot_ok = (pin_slot < SLOT_W'(NPIN));

    logic unused_bits;
    assign unused_bits = ^{cmd_data[TLB_DW-1:30], cmd_data[0], cmd_ov[NPIN-1:0]};

    always_comb begin
        d         = q;
        ins_slot  = '0;
        d.err_seq = 1'b0;
        d.err_arg = 1'b0;
        d.hit     = lk_any;
        d.pa      = lk_any ? lk_pa_c : '0;
        d.attr    = lk_any ? q.ent[lk_idx].attr : '0;

        case (op)
            OP_INS_ADDR: begin
                for (int i = 0; i < NORD; i++) begin
                    if (cmd_ov[NPIN+i]) begin
                        d.ent[NPIN+i].vld = 1'b0;
                        d.free[i]         = 1'b1;
                    end
                end
                ins_slot = q.pend ? q.pend_slot : vic_slot;
                if (!q.pend && vic_rr) begin
                    d.rr = vic_rr_next;
                end
                for (int i = 0; i < NORD; i++) begin
                    if (IW'(NPIN + i) == ins_slot) begin
                        d.free[i] = 1'b0;
                    end
                end
                d.ent[ins_slot].vld  = 1'b0;
                d.ent[ins_slot].lo   = page_lo;
                d.ent[ins_slot].hi   = page_hi;
                d.ent[ins_slot].ppn  = cmd_data[5 +: TLB_PPN_W];
                d.ent[ins_slot].attr = '0;
                d.pend               = 1'b1;
                d.pend_slot          = ins_slot;
            end
            OP_INS_PROT: begin
                d.pend = 1'b0;
                if (q.pend && (cmd_addr >= q.ent[q.pend_slot].lo)
                           && (cmd_addr <= q.ent[q.pend_slot].hi)) begin
                    d.ent[q.pend_slot].vld  = 1'b1;
                    d.ent[q.pend_slot].attr = {cmd_data[29:1], 1'b0};
                end else begin
                    d.err_seq = 1'b1;
                end
            end
            OP_PURGE_ADDR: begin
                for (int i = 0; i < NORD; i++) begin
                    if (cmd_ov[NPIN+i]) begin
                        d.ent[NPIN+i].vld = 1'b0;
                        d.free[i]         = 1'b1;
                    end
                end
            end
            OP_PURGE_ALL: begin
                for (int i = 0; i < NORD; i++) begin
                    d.ent[NPIN+i].vld = 1'b0;
                end
                d.free = '1;
                d.rr   = IW'(NPIN);
                d.pend = 1'b0;
            end
            OP_PIN_INS: begin
                if (slot_ok) begin
                    for (int p = 0; p < NPIN; p++) begin
                        if (pin_slot == SLOT_W'(p)) begin
                            d.ent[p].vld  = 1'b1;
                            d.ent[p].lo   = {pin_vpn, {TLB_PGB{1'b0}}};
                            d.ent[p].hi   = {pin_vpn, {TLB_PGB{1'b0}}}
                                          + ({pin_len, {TLB_PGB{1'b0}}} - 1'b1);
                            d.ent[p].ppn  = pin_ppn;
                            d.ent[p].attr = {1'b0, 1'b1, cmd_data[27:1], 1'b0};
                        end
                    end
                end else begin
                    d.err_arg = 1'b1;
                end
            end
            OP_PIN_PURGE: begin
                if (slot_ok) begin
                    for (int p = 0; p < NPIN; p++) begin
                        if (pin_slot == SLOT_W'(p)) begin
                            d.ent[p].vld = 1'b0;
                        end
                    end
                end else begin
                    d.err_arg = 1'b1;
                end
            end
            OP_PIN_PURGE_AL: begin
                for (int p = 0; p < NPIN; p++) begin
                    d.ent[p].vld = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.free <= '1;
            q.rr   <= IW'(NPIN);
        end else begin
            q <= d;
        end
    end

    assign lk_hit  = q.hit;
    assign lk_pa   = q.pa;
    assign lk_attr = q.attr;
    assign err_seq = q.err_seq;
    assign err_arg = q.err_arg;

    // ---------------- assertions ----------------
    logic [NPIN-1:0] pin_vld;
    logic [NORD-1:0] ord_vld;
    always_comb begin
        for (int p = 0; p < NPIN; p++) pin_vld[p] = q.ent[p].vld;
        for (int i = 0; i < NORD; i++) ord_vld[i] = q.ent[NPIN+i].vld;
    end

    assert_rr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rr >= IW'(NPIN)) && (q.rr <= IW'(NENT - 1)))
        else $error("round-robin pointer left the ordinary slots");

    assert_free_not_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.free & ord_vld) == '0)
        else $error("a free slot holds a valid entry");

    assert_pend_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INS_PROT) |=> !q.pend)
        else $error("pending insert survived a protection command");

    assert_pinned_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PURGE_ADDR) |=> (pin_vld == $past(pin_vld)))
        else $error("purge-by-address touched a pinned slot");

    assert_purge_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PURGE_ALL) |=> ((ord_vld == '0) && (&q.free) && !q.pend
                                  && (pin_vld == $past(pin_vld))))
        else $error("purge-all left ordinary state behind");

    assert_bad_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (((op == OP_PIN_INS) || (op == OP_PIN_PURGE)) && !slot_ok)
            |=> (q.err_arg && (pin_vld == $past(pin_vld))))
        else $error("out-of-range pinned slot was not rejected");

    for (genvar g = 0; g < NPIN; g++) begin : g_pin_chk
        assert_pin_td_R8: assert property (@(posedge clk) disable iff (!rst_n)
            q.ent[g].vld |-> (!q.ent[g].attr[29] && q.ent[g].attr[28]))
            else $error("pinned entry without forced T/D bits");
    end
endmodule

// File: tb/range_tlb_tb.sv
`timescale 1ns/1ps
module range_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [3:0]  pin_slot = '0;
    logic [19:0] pin_vpn = '0;
    logic [19:0] pin_ppn = '0;
    logic [19:0] pin_len = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic [29:0] lk_attr;
    logic        err_seq;
    logic        err_arg;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    range_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .pin_slot(pin_slot), .pin_vpn(pin_vpn),
        .pin_ppn(pin_ppn), .pin_len(pin_len), .lk_hit(lk_hit),
        .lk_pa(lk_pa), .lk_attr(lk_attr), .err_seq(err_seq), .err_arg(err_arg)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run hung (actual cycles %0d, expected < 50000)", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    // Lookup: drive at a falling edge, result registered at the next rising edge.
    task automatic look(input logic [31:0] a, input bit h, input logic [31:0] pa,
                        input logic [29:0] at, input string r);
        @(negedge clk);
        lk_addr = a;
        @(negedge clk);
        check({r, " hit"}, 64'(lk_hit), 64'(h));
        if (h) begin
            check({r, " pa"}, 64'(lk_pa), 64'(pa));
            check({r, " attr"}, 64'(lk_attr), 64'(at));
        end else begin
            check({r, " miss pa"}, 64'(lk_pa), 64'd0);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [31:0] a, input logic [31:0] dat,
                       input logic [3:0] s, input logic [19:0] vp, input logic [19:0] pp,
                       input logic [19:0] ln, input bit es, input bit ea, input string r);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = dat;
        pin_slot = s; pin_vpn = vp; pin_ppn = pp; pin_len = ln;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({r, " err_seq"}, 64'(err_seq), 64'(es));
        check({r, " err_arg"}, 64'(err_arg), 64'(ea));
    endtask

    task automatic ins(input logic [31:0] a, input logic [19:0] ppn, input logic [31:0] w,
                       input string r);
        cmd(3'd1, a, {7'd0, ppn, 5'h1F}, 4'd0, 20'd0, 20'd0, 20'd0, 1'b0, 1'b0, r);
        cmd(3'd2, a, w, 4'd0, 20'd0, 20'd0, 20'd0, 1'b0, 1'b0, r);
    endtask

    task automatic pins(input logic [3:0] s, input logic [19:0] vp, input logic [19:0] pp,
                        input logic [19:0] ln, input logic [31:0] w, input bit ea, input string r);
        cmd(3'd5, 32'd0, w, s, vp, pp, ln, 1'b0, ea, r);
    endtask

    function automatic logic [31:0] wordf(input int i);
        logic [31:0] w;
        w = 32'h8000_0001 | (32'(i + 1) << 1) | (32'(i & 1) << 19) | (32'(i & 3) << 20)
          | (32'((i >> 2) & 3) << 22) | (32'(i % 8) << 24) | (32'((i >> 1) & 1) << 27)
          | (32'(~i & 1) << 28) | (32'((i >> 2) & 1) << 29);
        return w;
    endfunction

    function automatic logic [29:0] oattr(input logic [31:0] w);
        return w[29:0] & 30'h3FFF_FFFE;
    endfunction

    function automatic logic [29:0] pattr(input logic [31:0] w);
        return (w[29:0] & 30'h0FFF_FFFE) | 30'h1000_0000;
    endfunction

    localparam logic [31:0] WP = 32'h2555_5555;

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 err_seq", 64'(err_seq), 64'd0);
        check("R11 err_arg", 64'(err_arg), 64'd0);
        rst_n = 1'b1;
        look(32'h1000_0000, 1'b0, 0, 0, "R11 empty");
        look(32'h0000_0000, 1'b0, 0, 0, "R11 empty zero");

        // R2/R4: fill the ordinary slots, sweep each page
        for (int i = 0; i < 12; i++) begin
            ins(32'h1000_0123 + 32'(i) * 32'h1000, 20'(32'h50 + i), wordf(i), "R2 fill");
        end
        for (int i = 0; i < 12; i++) begin
            look(32'h1000_0000 + 32'(i) * 32'h1000, 1'b1, 32'((32'h50 + i) << 12), oattr(wordf(i)), "R1 R4 first");
            look(32'h1000_0800 + 32'(i) * 32'h1000, 1'b1, 32'((32'h50 + i) << 12) + 32'h800, oattr(wordf(i)), "R1 mid");
            look(32'h1000_0FFF + 32'(i) * 32'h1000, 1'b1, 32'((32'h50 + i) << 12) + 32'hFFF, oattr(wordf(i)), "R2 last");
        end
        look(32'h0FFF_FFFF, 1'b0, 0, 0, "R1 below");
        look(32'h1000_C000, 1'b0, 0, 0, "R1 above");

        // R5: round robin starts at slot 4 (first page filled)
        ins(32'h2000_0000, 20'h111, wordf(0), "R5 evict1");
        look(32'h1000_0000, 1'b0, 0, 0, "R5 evicted first");
        look(32'h2000_0ABC, 1'b1, 32'h0011_1ABC, oattr(wordf(0)), "R5 new1");
        ins(32'h2000_1000, 20'h112, wordf(1), "R5 evict2");
        look(32'h1000_1000, 1'b0, 0, 0, "R5 evicted second");
        look(32'h1000_2000, 1'b1, 32'h0005_2000, oattr(wordf(2)), "R5 third kept");

        // R3: protection ordering
        cmd(3'd2, 32'h3000_0000, wordf(3), 0, 0, 0, 0, 1'b1, 1'b0, "R3 no pending");
        look(32'h3000_0000, 1'b0, 0, 0, "R3 no pending miss");
        cmd(3'd1, 32'h3000_0000, 32'h333 << 5, 0, 0, 0, 0, 1'b0, 1'b0, "R3 ins addr");
        look(32'h1000_2000, 1'b0, 0, 0, "R5 evicted third");
        cmd(3'd2, 32'h3000_1000, wordf(3), 0, 0, 0, 0, 1'b1, 1'b0, "R3 out of range");
        look(32'h3000_0000, 1'b0, 0, 0, "R3 out of range miss");
        cmd(3'd2, 32'h3000_0000, wordf(3), 0, 0, 0, 0, 1'b1, 1'b0, "R3 pending cleared");
        look(32'h3000_0000, 1'b0, 0, 0, "R3 cleared miss");

        // R2: re-insert an existing page purges it first
        cmd(3'd1, 32'h1000_5123, 32'h77 << 5, 0, 0, 0, 0, 1'b0, 1'b0, "R2 reinsert");
        look(32'h1000_5000, 1'b0, 0, 0, "R2 pending no hit");
        cmd(3'd2, 32'h1000_5FFF, wordf(7), 0, 0, 0, 0, 1'b0, 1'b0, "R2 complete");
        look(32'h1000_5000, 1'b1, 32'h0007_7000, oattr(wordf(7)), "R2 new base");
        look(32'h1000_5FFF, 1'b1, 32'h0007_7FFF, oattr(wordf(7)), "R2 new last");
        look(32'h1000_4000, 1'b1, 32'h0005_4000, oattr(wordf(4)), "R2 left neighbour");
        look(32'h1000_6000, 1'b1, 32'h0005_6000, oattr(wordf(6)), "R2 right neighbour");

        // R8: pinned multi-page range with forced T/D
        pins(4'd0, 20'h40000, 20'h80000, 20'd4, WP, 1'b0, "R8 pin0");
        look(32'h4000_0000, 1'b1, 32'h8000_0000, pattr(WP), "R8 start");
        look(32'h4000_3FFF, 1'b1, 32'h8000_3FFF, pattr(WP), "R8 last");
        look(32'h4000_4000, 1'b0, 0, 0, "R8 past last");

        // R1 priority and R6 pinned survives purge
        ins(32'h4000_1000, 20'h444, wordf(5), "R1 under pinned");
        look(32'h4000_1000, 1'b1, 32'h8000_1000, pattr(WP), "R1 lowest index");
        cmd(3'd3, 32'h4000_1800, 0, 0, 0, 0, 0, 1'b0, 1'b0, "R6 purge pinned area");
        look(32'h4000_1800, 1'b1, 32'h8000_1800, pattr(WP), "R6 pinned kept");
        cmd(3'd3, 32'h1000_4800, 0, 0, 0, 0, 0, 1'b0, 1'b0, "R6 purge ordinary");
        look(32'h1000_4000, 1'b0, 0, 0, "R6 purged");
        look(32'h1000_8000, 1'b1, 32'h0005_8000, oattr(wordf(8)), "R6 other kept");

        // R1 overlapping pinned slots
        pins(4'd2, 20'h48000, 20'h90000, 20'd2, 32'd0, 1'b0, "R8 pin2");
        pins(4'd1, 20'h48001, 20'hA0000, 20'd2, 32'd0, 1'b0, "R8 pin1");
        look(32'h4800_0000, 1'b1, 32'h9000_0000, 30'h1000_0000, "R1 only slot2");
        look(32'h4800_1000, 1'b1, 32'hA000_0000, 30'h1000_0000, "R1 slot1 wins");
        look(32'h4800_2FFF, 1'b1, 32'hA000_1FFF, 30'h1000_0000, "R1 slot1 end");

        // R9 bad slots
        pins(4'd4, 20'h70000, 20'h1, 20'd1, 32'd0, 1'b1, "R9 insert slot4");
        look(32'h7000_0000, 1'b0, 0, 0, "R9 no entry");
        pins(4'd15, 20'h70000, 20'h1, 20'd1, 32'd0, 1'b1, "R9 insert slot15");
        look(32'h7000_0000, 1'b0, 0, 0, "R9 no entry 15");
        cmd(3'd6, 0, 0, 4'd9, 0, 0, 0, 1'b0, 1'b1, "R9 purge slot9");
        look(32'h4000_0000, 1'b1, 32'h8000_0000, pattr(WP), "R9 pinned intact");

        // R10 pinned purges
        cmd(3'd6, 0, 0, 4'd1, 0, 0, 0, 1'b0, 1'b0, "R10 purge slot1");
        look(32'h4800_1000, 1'b1, 32'h9000_1000, 30'h1000_0000, "R10 slot2 visible");
        look(32'h4800_2000, 1'b0, 0, 0, "R10 slot1 gone");
        cmd(3'd6, 0, 0, 4'd0, 0, 0, 0, 1'b0, 1'b0, "R10 purge slot0");
        look(32'h4000_1000, 1'b0, 0, 0, "R10 R6 both gone");
        cmd(3'd7, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, "R10 purge all pinned");
        look(32'h4800_0000, 1'b0, 0, 0, "R10 slot2 gone");
        look(32'h1000_8000, 1'b1, 32'h0005_8000, oattr(wordf(8)), "R10 ordinary kept");

        // R7 purge-all
        pins(4'd3, 20'h0C000, 20'h00C00, 20'd1, 32'd0, 1'b0, "R7 pin3");
        cmd(3'd1, 32'h1000_8000, 32'h99 << 5, 0, 0, 0, 0, 1'b0, 1'b0, "R7 pending");
        cmd(3'd4, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, "R7 purge all");
        look(32'h1000_B000, 1'b0, 0, 0, "R7 ordinary gone");
        look(32'h2000_0000, 1'b0, 0, 0, "R7 ordinary gone 2");
        look(32'h0C00_0010, 1'b1, 32'h00C0_0010, 30'h1000_0000, "R7 pinned kept");
        cmd(3'd2, 32'h1000_8000, wordf(2), 0, 0, 0, 0, 1'b1, 1'b0, "R7 pending cancelled");
        look(32'h1000_8000, 1'b0, 0, 0, "R7 cancelled miss");
        for (int i = 0; i < 12; i++) begin
            ins(32'h5000_0000 + 32'(i) * 32'h1000, 20'(32'h600 + i), wordf(i), "R7 refill");
        end
        for (int i = 0; i < 12; i++) begin
            look(32'h5000_0FFF + 32'(i) * 32'h1000, 1'b1, 32'((32'h600 + i) << 12) + 32'hFFF, oattr(wordf(i)), "R7 refill hit");
        end
        ins(32'h6000_0000, 20'h700, wordf(9), "R7 R5 evict after reset");
        look(32'h5000_0000, 1'b0, 0, 0, "R7 pointer reset");
        look(32'h5000_4000, 1'b1, 32'h0060_4000, oattr(wordf(4)), "R7 other kept");
        look(32'h6000_0000, 1'b1, 32'h0070_0000, oattr(wordf(9)), "R7 new hit");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule